// File: doc/BRIEF.md
# Six-Channel DMA Request Arbiter

This block decides which of six DMA channels may use the transfer engine next. It grants one channel at a time. A channel takes part in arbitration only when its own enable is set, the controller-wide enable is set, and none of its transfer-end flag, the NMI flag or the address-error flag is raised. A channel configured for automatic requesting competes whenever it is qualified. A channel driven by an external or peripheral request line competes only after a request arrives while it is qualified. Such a request is latched until the channel is served or loses qualification.

A 2-bit field selects how competing channels are ranked. Code 00 ranks the channels in plain numeric order. Code 01 uses a fixed order in which channel 1 sits below channels 2 and 3. Code 11 rotates priority so that the channel served last becomes the lowest. Code 10 is not a legal setting. If it is programmed, the block ranks as for code 00 and raises a sticky flag. A grant is held until the engine pulses a done strobe. The grant is dropped at once if the granted channel loses qualification.

Top module: `dma_req_arbiter`

## Requirements
- R1: A channel is granted only when chan_en_i[n]=1, glob_en_i=1, chan_end_i[n]=0, nmi_flag_i=0 and addr_err_i=0; if any of these fails, that channel is never newly granted.
- R2: A qualified channel with chan_auto_i[n]=1 competes without any activity on chan_req_i[n].
- R3: For a channel with chan_auto_i[n]=0, a high level on chan_req_i[n] counts only in a cycle where the channel is qualified. A request seen while the channel is not qualified is ignored. A counted request stays pending after the line falls, until the channel is granted and its done strobe arrives, or until it loses qualification.
- R4: With prio_mode_i=2'b00, the requesting channel with the lowest number wins (0 highest, 5 lowest).
- R5: With prio_mode_i=2'b01, the rank from highest to lowest is channel 0, 2, 3, 1, 4, 5.
- R6: With prio_mode_i=2'b11, the search starts at the channel after the one granted most recently and wraps from 5 to 0. After reset, channel 0 is searched first.
- R7: With prio_mode_i=2'b10, ranking is as for 2'b00 and bad_mode_o goes to 1 on the next clock edge. The flag stays 1 until reset, whatever mode is programmed later.
- R8: A grant is held while the granted channel stays qualified and xfer_done_i is low, even if a higher-ranked channel starts requesting. After a cycle with xfer_done_i=1 and a grant active, the next cycle shows no grant. A new grant from arbitration appears one cycle after that.
- R9: If the granted channel loses qualification (for example its enable or transfer-end flag changes), the grant is removed on the next clock edge.
- R10: grant_o is one-hot or zero, and grant_valid_o equals the OR of grant_o. When idle with a pending request, a grant appears on the next clock edge. With no request, grant_o=0 and grant_valid_o=0.
- R11: While rst is high, and in the first cycle after it, grant_o=0, grant_valid_o=0 and bad_mode_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_req_i | input | 6 | Raw request lines, one per channel |
| chan_auto_i | input | 6 | 1: channel requests automatically when qualified |
| chan_en_i | input | 6 | Per-channel transfer enable |
| chan_end_i | input | 6 | Per-channel transfer-end flag (blocks the channel) |
| glob_en_i | input | 1 | Controller-wide enable |
| nmi_flag_i | input | 1 | NMI flag (blocks all channels) |
| addr_err_i | input | 1 | Address-error flag (blocks all channels) |
| prio_mode_i | input | 2 | 00 numeric order, 01 alternate fixed order, 10 illegal, 11 rotating |
| xfer_done_i | input | 1 | Pulse ending the transfer of the granted channel |
| grant_o | output | 6 | One-hot grant |
| grant_valid_o | output | 1 | A grant is active |
| bad_mode_o | output | 1 | Sticky flag: code 10 was programmed |

## Verification
The assertions check on every cycle the following properties:
- the grant is one-hot, and grant_valid_o agrees with it;
- a new grant only goes to a channel that was requesting;
- an idle arbiter with a request always grants;
- a held grant does not move before done;
- done or a lost qualification removes the grant within one cycle;
- the illegal-mode flag is set and then stays set.

Only the bench scenarios can show which channel wins under each of the three ranking schemes. They also cover the rotating pointer's wrap and its reset position, the ignoring of requests seen while a channel is disabled, and a latched external request outliving its pulse.

// File: rtl/dmarb_pkg.sv
package dmarb_pkg;

    parameter int unsigned N_CH = 6;
    localparam int unsigned IDX_W = $clog2(N_CH);

    typedef logic [N_CH-1:0]  chmask_t;
    typedef logic [IDX_W-1:0] chidx_t;

    typedef enum logic [1:0] {
        MODE_FIX_A = 2'b00,
        MODE_FIX_B = 2'b01,
        MODE_RSVD  = 2'b10,
        MODE_ROUND = 2'b11
    } prio_mode_e;

    typedef struct packed {
        logic   valid;
        chidx_t idx;
    } pick_t;

    // Controller-wide gating flags
    typedef struct packed {
        logic enable;
        logic nmi;
        logic addr_err;
    } glob_flags_t;

    // Channel held at rank position pos in the alternate fixed order
    function automatic chidx_t fixb_chan(int unsigned pos);
        chidx_t c;
        case (pos)
            0:       c = chidx_t'(0);
            1:       c = chidx_t'(2);
            2:       c = chidx_t'(3);
            3:       c = chidx_t'(1);
            default: c = chidx_t'(pos);
        endcase
        return c;
    endfunction

    // base + off modulo N_CH, off below 2*N_CH
    function automatic chidx_t wrap_add(chidx_t base, int unsigned off);
        int unsigned s;
        s = int'(base) + off;
        if (s >= N_CH) s = s - N_CH;
        if (s >= N_CH) s = s - N_CH;
        return chidx_t'(s);
    endfunction

    function automatic chmask_t idx2mask(chidx_t i);
        chmask_t m;
        m = '0;
        m[i] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/dmarb_qualify.sv
module dmarb_qualify
    import dmarb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  chmask_t     req_i,
    input  chmask_t     auto_i,
    input  chmask_t     en_i,
    input  chmask_t     end_i,
    input  glob_flags_t glob_i,
    input  chmask_t     clr_i,
    output chmask_t     qual_o,
    output chmask_t     eff_req_o
);

    logic    glob_ok;
    chmask_t pend_q;

    assign glob_ok = glob_i.enable & ~glob_i.nmi & ~glob_i.addr_err;

    for (genvar n = 0; n < N_CH; n++) begin : g_ch
        assign qual_o[n]    = glob_ok & en_i[n] & ~end_i[n];
        assign eff_req_o[n] = qual_o[n] & (auto_i[n] | pend_q[n] | req_i[n]);

        // Latched external request: only captured while qualified
        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q[n] <= 1'b0;
            end else begin
                pend_q[n] <= qual_o[n] & ~auto_i[n] & ~clr_i[n]
                           & (pend_q[n] | req_i[n]);
            end
        end
    end

endmodule

// File: rtl/dmarb_mode.sv
module dmarb_mode
    import dmarb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_raw_i,
    output prio_mode_e mode_o,
    output logic       bad_o
);

    prio_mode_e raw;
    logic       bad_q;

    assign raw    = prio_mode_e'(mode_raw_i);
    assign mode_o = (raw == MODE_RSVD) ? MODE_FIX_A : raw;
    assign bad_o  = bad_q;

    always_ff @(posedge clk) begin
        if (rst)                    bad_q <= 1'b0;
        else if (raw == MODE_RSVD)  bad_q <= 1'b1;
    end

    AST_BAD_MODE_SET: assert property (@(posedge clk) disable iff (rst)
        (mode_raw_i == 2'b10) |=> bad_q); // R7

    AST_BAD_MODE_STICKY: assert property (@(posedge clk) disable iff (rst)
        bad_q |=> bad_q); // R7

endmodule

// File: rtl/dmarb_select.sv
module dmarb_select
    import dmarb_pkg::*;
(
    input  chmask_t    req_i,
    input  prio_mode_e mode_i,
    input  chidx_t     last_i,
    output pick_t      pick_o
);

    pick_t pick_a, pick_b, pick_r;

    // Scan from lowest rank upward so the highest rank overwrites last
    always_comb begin
        pick_a = '0;
        pick_b = '0;
        pick_r = '0;
        for (int p = N_CH - 1; p >= 0; p--) begin
            if (req_i[chidx_t'(p)]) begin
                pick_a.valid = 1'b1;
                pick_a.idx   = chidx_t'(p);
            end
            if (req_i[fixb_chan(p)]) begin
                pick_b.valid = 1'b1;
                pick_b.idx   = fixb_chan(p);
            end
            if (req_i[wrap_add(last_i, p + 1)]) begin
                pick_r.valid = 1'b1;
                pick_r.idx   = wrap_add(last_i, p + 1);
            end
        end
    end

    always_comb begin
        case (mode_i)
            MODE_FIX_B: pick_o = pick_b;
            MODE_ROUND: pick_o = pick_r;
            default:    pick_o = pick_a;
        endcase
    end

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
    import dmarb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [N_CH-1:0]  chan_req_i,
    input  logic [N_CH-1:0]  chan_auto_i,
    input  logic [N_CH-1:0]  chan_en_i,
    input  logic [N_CH-1:0]  chan_end_i,
    input  logic             glob_en_i,
    input  logic             nmi_flag_i,
    input  logic             addr_err_i,
    input  logic [1:0]       prio_mode_i,
    input  logic             xfer_done_i,
    output logic [N_CH-1:0]  grant_o,
    output logic             grant_valid_o,
    output logic             bad_mode_o
);

    glob_flags_t glob;
    chmask_t     qual, eff_req, clr_mask;
    chmask_t     grant_q, grant_d;
    logic        gvalid_q, gvalid_d;
    chidx_t      last_q, last_d;
    prio_mode_e  mode_eff;
    pick_t       pick;

    assign glob = '{enable: glob_en_i, nmi: nmi_flag_i, addr_err: addr_err_i};
    assign clr_mask = (gvalid_q && xfer_done_i) ? grant_q : '0;

    dmarb_qualify u_qual (
        .clk      (clk),
        .rst      (rst),
        .req_i    (chan_req_i),
        .auto_i   (chan_auto_i),
        .en_i     (chan_en_i),
        .end_i    (chan_end_i),
        .glob_i   (glob),
        .clr_i    (clr_mask),
        .qual_o   (qual),
        .eff_req_o(eff_req)
    );

    dmarb_mode u_mode (
        .clk       (clk),
        .rst       (rst),
        .mode_raw_i(prio_mode_i),
        .mode_o    (mode_eff),
        .bad_o     (bad_mode_o)
    );

    dmarb_select u_sel (
        .req_i (eff_req),
        .mode_i(mode_eff),
        .last_i(last_q),
        .pick_o(pick)
    );

    always_comb begin
        grant_d  = grant_q;
        gvalid_d = gvalid_q;
        last_d   = last_q;
        if (gvalid_q) begin
            if (xfer_done_i || ((grant_q & qual) == '0)) begin
                grant_d  = '0;
                gvalid_d = 1'b0;
            end
        end else if (pick.valid) begin
            grant_d  = idx2mask(pick.idx);
            gvalid_d = 1'b1;
            last_d   = pick.idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q  <= '0;
            gvalid_q <= 1'b0;
            last_q   <= chidx_t'(N_CH - 1);
        end else begin
            grant_q  <= grant_d;
            gvalid_q <= gvalid_d;
            last_q   <= last_d;
        end
    end

    assign grant_o       = grant_q;
    assign grant_valid_o = gvalid_q;

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_q)); // R10

    AST_VALID_MATCHES_GRANT: assert property (@(posedge clk) disable iff (rst)
        gvalid_q == (grant_q != '0)); // R10

    AST_NEW_GRANT_REQUESTED: assert property (@(posedge clk) disable iff (rst)
        !gvalid_q |=> ((grant_q & ~$past(eff_req)) == '0)); // R1

    AST_IDLE_TAKES_REQUEST: assert property (@(posedge clk) disable iff (rst)
        (!gvalid_q && (eff_req != '0)) |=> gvalid_q); // R10

    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (rst)
        (gvalid_q && !xfer_done_i && ((grant_q & qual) != '0)) |=> $stable(grant_q)); // R8

    AST_RELEASE_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        (gvalid_q && xfer_done_i) |=> !gvalid_q); // R8

    AST_DROP_ON_DISQUAL: assert property (@(posedge clk) disable iff (rst)
        (gvalid_q && ((grant_q & qual) == '0)) |=> !gvalid_q); // R9

endmodule

// File: tb/dma_req_arbiter_tb_top.sv
`timescale 1ns/1ps
module dma_req_arbiter_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] chan_req = '0, chan_auto = '0, chan_en = '0, chan_end = '0;
    logic       glob_en = 1'b0, nmi_flag = 1'b0, addr_err = 1'b0;
    logic [1:0] prio_mode = 2'b00;
    logic       xfer_done = 1'b0;
    logic [5:0] grant;
    logic       grant_valid, bad_mode;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dma_req_arbiter dut_i (
        .clk(clk), .rst(rst),
        .chan_req_i(chan_req), .chan_auto_i(chan_auto),
        .chan_en_i(chan_en), .chan_end_i(chan_end),
        .glob_en_i(glob_en), .nmi_flag_i(nmi_flag), .addr_err_i(addr_err),
        .prio_mode_i(prio_mode), .xfer_done_i(xfer_done),
        .grant_o(grant), .grant_valid_o(grant_valid), .bad_mode_o(bad_mode)
    );

    // {mode[1:0], enabled mask[5:0], expected grant[5:0]}, all channels auto
    localparam logic [13:0] VEC [12] = '{
        {2'b00, 6'h3F, 6'h01},
        {2'b00, 6'h3E, 6'h02},
        {2'b00, 6'h30, 6'h10},
        {2'b00, 6'h20, 6'h20},
        {2'b00, 6'h00, 6'h00},
        {2'b01, 6'h3F, 6'h01},
        {2'b01, 6'h0E, 6'h04},
        {2'b01, 6'h0A, 6'h08},
        {2'b01, 6'h32, 6'h02},
        {2'b01, 6'h12, 6'h02},
        {2'b01, 6'h30, 6'h10},
        {2'b10, 6'h0E, 6'h02}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        chan_req = '0; chan_auto = '0; chan_en = '0; chan_end = '0;
        glob_en = 1'b1; nmi_flag = 1'b0; addr_err = 1'b0;
        prio_mode = 2'b00; xfer_done = 1'b0;
        step(); step();
        rst = 1'b0;
        step();
    endtask

    task automatic clear_grant();
        chan_en = '0;
        step();
    endtask

    // pulse done, expect no grant, then the given next grant
    task automatic done_then(input string tag, input logic [5:0] nxt);
        xfer_done = 1'b1;
        step();
        xfer_done = 1'b0;
        chk({tag, " gap after done"}, {1'b0, grant_valid, grant}, 8'h00);
        step();
        chk({tag, " next grant"}, {2'b00, grant}, {2'b00, nxt});
    endtask

    initial begin
        do_reset();
        chk("R11 reset grant/valid/flag", {bad_mode, grant_valid, grant}, 8'h00);

        // R6 rotating order starting at channel 0 after reset
        prio_mode = 2'b11; chan_auto = 6'h3F; chan_en = 6'h3F;
        step();
        chk("R6 first rotating grant", {2'b00, grant}, 8'h01);
        for (int k = 1; k <= 6; k++) begin
            done_then("R6 rotate", 6'(1 << (k % 6)));
        end
        // holding ch0; shrink mask to ch2 and ch5
        chan_en = 6'h24;
        step();
        chk("R9 drop on disable", {1'b0, grant_valid, grant}, 8'h00);
        step();
        chk("R6 skip to ch2", {2'b00, grant}, 8'h04);
        done_then("R6 ch5 after ch2", 6'h20);
        done_then("R6 wrap to ch2", 6'h04);

        // R4 R5 R7 R10 R2 table
        do_reset();
        for (int v = 0; v < 12; v++) begin
            clear_grant();
            prio_mode = VEC[v][13:12];
            chan_auto = 6'h3F;
            chan_en   = VEC[v][11:6];
            step();
            chk($sformatf("R4/R5/R7/R10/R2 vector %0d", v),
                {1'b0, grant_valid, grant}, {1'b0, (VEC[v][5:0] != 0), VEC[v][5:0]});
        end
        chk("R7 flag set", {7'b0, bad_mode}, 8'h01);
        prio_mode = 2'b00;
        step(); step();
        chk("R7 flag sticky", {7'b0, bad_mode}, 8'h01);

        // R1 gating
        clear_grant();
        chan_auto = 6'h01; chan_en = 6'h01; glob_en = 1'b0;
        step();
        chk("R1 global enable off", {1'b0, grant_valid, grant}, 8'h00);
        glob_en = 1'b1; nmi_flag = 1'b1;
        step();
        chk("R1 nmi flag", {1'b0, grant_valid, grant}, 8'h00);
        nmi_flag = 1'b0; addr_err = 1'b1;
        step();
        chk("R1 address error", {1'b0, grant_valid, grant}, 8'h00);
        addr_err = 1'b0; chan_end = 6'h01;
        step();
        chk("R1 transfer end", {1'b0, grant_valid, grant}, 8'h00);
        chan_end = 6'h00;
        step();
        chk("R1 all gates open", {1'b0, grant_valid, grant}, 8'h41);
        // R9 transfer-end while granted
        chan_end = 6'h01;
        step();
        chk("R9 drop on transfer end", {1'b0, grant_valid, grant}, 8'h00);
        chan_end = 6'h00;

        // R8 hold against higher rank
        clear_grant();
        prio_mode = 2'b00; chan_auto = 6'h3F; chan_en = 6'h08;
        step();
        chk("R8 initial grant ch3", {2'b00, grant}, 8'h08);
        chan_en = 6'h09;
        step(); step(); step();
        chk("R8 held despite ch0", {2'b00, grant}, 8'h08);
        done_then("R8 release", 6'h01);

        // R3 external requests
        clear_grant();
        chan_auto = 6'h00; chan_req = 6'h02;
        step();
        chan_req = 6'h00; chan_en = 6'h02;
        step(); step();
        chk("R3 request while disabled ignored", {1'b0, grant_valid, grant}, 8'h00);
        chan_auto = 6'h01; chan_en = 6'h03;
        step();
        chk("R3 auto ch0 granted", {2'b00, grant}, 8'h01);
        chan_req = 6'h02;
        step();
        chan_req = 6'h00; chan_en = 6'h02;
        step();
        chk("R9 ch0 dropped", {1'b0, grant_valid, grant}, 8'h00);
        step();
        chk("R3 latched request served", {2'b00, grant}, 8'h02);
        done_then("R3 pending cleared", 6'h00);

        // R11 reset clears sticky flag
        prio_mode = 2'b10;
        step();
        do_reset();
        chk("R11 flag cleared by reset", {bad_mode, grant_valid, grant}, 8'h00);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog R8 actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule